// File: doc/BRIEF.md
# Vector Workload Frequency License Controller

This block watches the instruction classes one hardware thread retires and chooses a frequency cap level for that thread. Each retired instruction is described by its vector width (scalar, 128, 256 or 512 bits) and whether it is a heavy operation (floating-point math or integer multiply) or a light one. From that stream the block keeps a 2-bit license level and a 7-bit ratio code, in percent of the full boost ratio, which a clock controller downstream applies. One instance serves exactly one thread.

Some classes move the level up on the very next cycle (hard trigger). Others move it only once a programmable number of matching instructions has been counted (soft trigger), with a per-level counter that forgets its progress after a programmable quiet window. Once raised, the level steps back down one level at a time after a programmable hold-off with no instruction that justifies the current level. A mode input selects between a three-level scheme and a two-level scheme in which the reduced level is only used while single-core boost is active, and a disable input pins the level at full ratio.

Top module: `vlic_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the level is 0 and the ratio is 100.
- R2: The ratio is 100 at level 0 in both modes; in mode 0 level 1 gives 85 and level 2 gives 60; in mode 1 any non-zero level gives 97. Width codes are 0 scalar, 1 128-bit, 2 256-bit, 3 512-bit; heavy is 1 for heavy operations.
- R3: In mode 0, a retired light 512-bit instruction raises the level to at least 1 on the clock edge at which it is sampled, visible the following cycle.
- R4: In mode 0, heavy 256-bit instructions counted while the level is 0 raise the level to 1 at the edge sampling the Nth one, N being the soft threshold (0 acts as 1).
- R5: In mode 0, heavy 512-bit instructions counted while the level is below 2 raise it to 2 at the edge sampling the Nth one, under the same threshold.
- R6: When the window setting is non-zero and that many consecutive cycles pass with no instruction of a soft class, that class's count restarts from zero; a window of 0 never expires.
- R7: Scalar and 128-bit instructions, and light 256-bit instructions, never raise the level.
- R8: A non-zero level drops by exactly one after hold-off consecutive cycles (0 acts as 1) in which no instruction arrives whose class target is at least the current level; the class target is 1 for heavy 256-bit and light 512-bit, 2 for heavy 512-bit in mode 0, and 1 for any 512-bit with boost in mode 1.
- R9: A raise requested in the same cycle a fall would happen wins, and the level goes to the requested value.
- R10: In mode 1, any 512-bit instruction hard-triggers level 1 only while single-core boost is high; level 2 is never entered and nothing raises the level while boost is low.
- R11: While disable is high, the level becomes 0 at the next edge and stays 0 for every instruction class.
- R12: A soft count is held at zero while the level is already at or above its target, so progress made before a grant never carries over after the level falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_disable | input | 1 | Suppress all reductions |
| cfg_mode | input | 1 | 0 three-level scheme, 1 two-level boost scheme |
| cfg_soft_thresh | input | 6 | Matching instructions needed for a soft raise |
| cfg_window | input | 8 | Quiet cycles that clear a soft count (0 never) |
| cfg_holdoff | input | 10 | Cycles without a keeping instruction before one step down |
| single_core_boost | input | 1 | Single-core boost active (used in mode 1) |
| retire_vld | input | 1 | An instruction retires this cycle |
| retire_width | input | 2 | Vector width code of the retired instruction |
| retire_heavy | input | 1 | Retired instruction is a heavy operation |
| lic_level | output | 2 | Current license level |
| lic_ratio | output | 7 | Frequency ratio code in percent |

## Verification
The assertions take for granted that the configuration inputs do not change in the same cycle as the instruction they are meant to govern, and that the width and heavy inputs are meaningful only with retire_vld high. The stimulus changes configuration only between cycles, at segment boundaries of the random run, and keeps thresholds, windows and hold-offs small so that raises, window expiry and step-downs all occur many times; directed sequences place a raise on the exact cycle a hold-off expires and switch disable and mode while a level is held.

// File: rtl/vlic_pkg.sv
`timescale 1ns/1ps
// vlic_pkg: shared constants, width codes and the level-to-ratio table.
// Assumes level codes 0..2 with 0 the unrestricted level.
package vlic_pkg;
    localparam int LVL_W    = 2;
    localparam int NUM_LVL  = 3;
    localparam int NUM_SOFT = NUM_LVL - 1;
    localparam int RATIO_W  = 7;

    typedef enum logic [1:0] {
        VW_SCALAR = 2'd0,
        VW_128    = 2'd1,
        VW_256    = 2'd2,
        VW_512    = 2'd3
    } vwidth_e;

    localparam logic [RATIO_W-1:0] RATIO_FULL  = 7'd100;
    localparam logic [RATIO_W-1:0] RATIO_MID   = 7'd85;
    localparam logic [RATIO_W-1:0] RATIO_LOW   = 7'd60;
    localparam logic [RATIO_W-1:0] RATIO_BOOST = 7'd97;

    // Ratio code for a level under the selected scheme.
    function automatic logic [RATIO_W-1:0] ratio_of(input logic mode, input logic [LVL_W-1:0] lvl);
        logic [RATIO_W-1:0] r;
        if (lvl == '0)          r = RATIO_FULL;
        else if (mode)          r = RATIO_BOOST;
        else if (lvl == 2'd1)   r = RATIO_MID;
        else                    r = RATIO_LOW;
        return r;
    endfunction
endpackage

// File: rtl/vlic_classify.sv
`timescale 1ns/1ps
// vlic_classify: maps one retired instruction to a hard target level,
// a per-level soft hit and the class target used to keep a level.
// Assumes width/heavy are meaningful only when vld is high. Purely combinational.
module vlic_classify
    import vlic_pkg::*;
#(
    parameter int LW = LVL_W,
    parameter int NS = NUM_SOFT
) (
    input  logic          vld,
    input  logic [1:0]    width,
    input  logic          heavy,
    input  logic          mode,
    input  logic          boost,
    input  logic          dis,
    output logic [LW-1:0] hard_tgt,
    output logic [NS-1:0] soft_hit,
    output logic [LW-1:0] cls_tgt
);
    vwidth_e w;
    assign w = vwidth_e'(width);

    // Decode class into trigger kind and target level.
    always_comb begin
        hard_tgt = '0;
        soft_hit = '0;
        cls_tgt  = '0;
        if (vld && !dis) begin
            if (!mode) begin
                if (w == VW_512) begin
                    if (heavy) begin
                        soft_hit[1] = 1'b1;
                        cls_tgt     = LW'(2);
                    end else begin
                        hard_tgt = LW'(1);
                        cls_tgt  = LW'(1);
                    end
                end else if (w == VW_256 && heavy) begin
                    soft_hit[0] = 1'b1;
                    cls_tgt     = LW'(1);
                end
            end else if (w == VW_512 && boost) begin
                hard_tgt = LW'(1);
                cls_tgt  = LW'(1);
            end
        end
    end
endmodule

// File: rtl/vlic_soft_count.sv
`timescale 1ns/1ps
// vlic_soft_count: counts matching instructions toward one target level and
// pulses fire on the edge where the count reaches the threshold.
// Assumes lvl is the registered license level; the count is held at zero
// while lvl already meets the target, and a quiet window clears it.
module vlic_soft_count #(
    parameter int CNT_W  = 6,
    parameter int WIN_W  = 8,
    parameter int LW     = 2,
    parameter int TARGET = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dis,
    input  logic [LW-1:0]    lvl,
    input  logic             hit,
    input  logic [CNT_W-1:0] thresh,
    input  logic [WIN_W-1:0] window,
    output logic             fire
);
    localparam logic [LW-1:0] TGT = LW'(TARGET);

    logic [CNT_W-1:0] cnt_q;
    logic [WIN_W-1:0] idle_q;
    logic [CNT_W:0]   thr_eff;
    logic [CNT_W:0]   cnt_inc;
    logic [WIN_W:0]   idle_inc;
    logic             granted;
    logic             win_expire;

    // Effective threshold and next-count arithmetic.
    always_comb begin
        thr_eff    = (thresh == '0) ? (CNT_W+1)'(1) : {1'b0, thresh};
        cnt_inc    = {1'b0, cnt_q} + 1'b1;
        idle_inc   = {1'b0, idle_q} + 1'b1;
        granted    = dis || (lvl >= TGT);
        win_expire = (window != '0) && (idle_inc >= {1'b0, window});
        fire       = !granted && hit && (cnt_inc >= thr_eff);
    end

    // Count and quiet-window state.
    always_ff @(posedge clk) begin
        if (!rst_n || granted) begin
            cnt_q  <= '0;
            idle_q <= '0;
        end else if (hit) begin
            idle_q <= '0;
            cnt_q  <= fire ? '0 : cnt_inc[CNT_W-1:0];
        end else if (win_expire) begin
            cnt_q  <= '0;
            idle_q <= '0;
        end else if (idle_q != '1) begin
            idle_q <= idle_inc[WIN_W-1:0];
        end
    end

    // R12: once the level meets the target, the count is empty next cycle.
    a_r12_clear_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl >= TGT) |=> (cnt_q == '0));
    // R4: a soft raise only ever comes from a matching instruction.
    a_r4_fire_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> hit);
    // R6: an expired window leaves no partial count behind.
    a_r6_window_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && win_expire) |=> (cnt_q == '0));
endmodule

// File: rtl/vlic_level.sv
`timescale 1ns/1ps
// vlic_level: holds the license level, applies the highest requested raise,
// and steps down one level after a hold-off without a keeping instruction.
// Assumes raise requests are valid for the current cycle only.
module vlic_level #(
    parameter int LW     = 2,
    parameter int NS     = 2,
    parameter int HOLD_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dis,
    input  logic [LW-1:0]     hard_tgt,
    input  logic [NS-1:0]     fire,
    input  logic [LW-1:0]     cls_tgt,
    input  logic [HOLD_W-1:0] holdoff,
    output logic [LW-1:0]     lvl_o
);
    logic [LW-1:0]     lvl_q;
    logic [HOLD_W-1:0] hold_q;
    logic [LW-1:0]     raise_tgt;
    logic [HOLD_W:0]   hold_lim;
    logic [HOLD_W:0]   hold_inc;
    logic              keep;

    // Highest requested level this cycle.
    always_comb begin
        raise_tgt = hard_tgt;
        for (int i = 0; i < NS; i++) begin
            if (fire[i] && (LW'(i + 1) > raise_tgt))
                raise_tgt = LW'(i + 1);
        end
    end

    // Hold-off limit and keep decision.
    always_comb begin
        hold_lim = (holdoff == '0) ? (HOLD_W+1)'(1) : {1'b0, holdoff};
        hold_inc = {1'b0, hold_q} + 1'b1;
        keep     = (lvl_q == '0) || ((cls_tgt != '0) && (cls_tgt >= lvl_q));
    end

    // Level register with raise-before-fall priority.
    always_ff @(posedge clk) begin
        if (!rst_n || dis) begin
            lvl_q  <= '0;
            hold_q <= '0;
        end else if (raise_tgt > lvl_q) begin
            lvl_q  <= raise_tgt;
            hold_q <= '0;
        end else if (keep) begin
            hold_q <= '0;
        end else if (hold_inc >= hold_lim) begin
            lvl_q  <= lvl_q - 1'b1;
            hold_q <= '0;
        end else begin
            hold_q <= hold_inc[HOLD_W-1:0];
        end
    end

    assign lvl_o = lvl_q;

    // R11: disable forces level 0 on the next edge.
    a_r11_disable_zero: assert property (@(posedge clk) disable iff (!rst_n)
        dis |=> (lvl_q == '0));
    // R8: without disable, a fall is always exactly one step.
    a_r8_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!dis) && (lvl_q < $past(lvl_q))) |-> (lvl_q + 1'b1 == $past(lvl_q)));
    // R9: a pending raise is taken regardless of hold-off expiry.
    a_r9_raise_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!dis && (raise_tgt > lvl_q)) |=> (lvl_q == $past(raise_tgt)));
endmodule

// File: rtl/vlic_ctrl.sv
`timescale 1ns/1ps
// vlic_ctrl: per-thread frequency license controller. Classifies retired
// instructions, runs one soft counter per reduced level, holds the level and
// drives the ratio code. Assumes configuration is quasi-static.
module vlic_ctrl
    import vlic_pkg::*;
#(
    parameter int CNT_W  = 6,
    parameter int WIN_W  = 8,
    parameter int HOLD_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_disable,
    input  logic               cfg_mode,
    input  logic [CNT_W-1:0]   cfg_soft_thresh,
    input  logic [WIN_W-1:0]   cfg_window,
    input  logic [HOLD_W-1:0]  cfg_holdoff,
    input  logic               single_core_boost,
    input  logic               retire_vld,
    input  logic [1:0]         retire_width,
    input  logic               retire_heavy,
    output logic [LVL_W-1:0]   lic_level,
    output logic [RATIO_W-1:0] lic_ratio
);
    logic [LVL_W-1:0]    hard_tgt;
    logic [LVL_W-1:0]    cls_tgt;
    logic [NUM_SOFT-1:0] soft_hit;
    logic [NUM_SOFT-1:0] soft_fire;
    logic [LVL_W-1:0]    lvl;

    vlic_classify #(.LW(LVL_W), .NS(NUM_SOFT)) u_cls (
        .vld      (retire_vld),
        .width    (retire_width),
        .heavy    (retire_heavy),
        .mode     (cfg_mode),
        .boost    (single_core_boost),
        .dis      (cfg_disable),
        .hard_tgt (hard_tgt),
        .soft_hit (soft_hit),
        .cls_tgt  (cls_tgt)
    );

    for (genvar g = 0; g < NUM_SOFT; g++) begin : g_soft
        vlic_soft_count #(
            .CNT_W (CNT_W),
            .WIN_W (WIN_W),
            .LW    (LVL_W),
            .TARGET(g + 1)
        ) u_soft (
            .clk    (clk),
            .rst_n  (rst_n),
            .dis    (cfg_disable),
            .lvl    (lvl),
            .hit    (soft_hit[g]),
            .thresh (cfg_soft_thresh),
            .window (cfg_window),
            .fire   (soft_fire[g])
        );
    end

    vlic_level #(.LW(LVL_W), .NS(NUM_SOFT), .HOLD_W(HOLD_W)) u_lvl (
        .clk      (clk),
        .rst_n    (rst_n),
        .dis      (cfg_disable),
        .hard_tgt (hard_tgt),
        .fire     (soft_fire),
        .cls_tgt  (cls_tgt),
        .holdoff  (cfg_holdoff),
        .lvl_o    (lvl)
    );

    // Level and ratio outputs.
    always_comb begin
        lic_level = lvl;
        lic_ratio = ratio_of(cfg_mode, lvl);
    end

    // R3: a light 512-bit instruction in mode 0 reaches level 1 next cycle.
    a_r3_hard_next: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_vld && !cfg_disable && !cfg_mode && retire_width == 2'd3 && !retire_heavy)
        |=> (lic_level != '0));
    // R7: narrow instructions never lift the level off 0.
    a_r7_narrow_no_raise: assert property (@(posedge clk) disable iff (!rst_n)
        (!(retire_vld && retire_width >= 2'd2) && lic_level == '0) |=> (lic_level == '0));
    // R10: mode 1 without boost cannot leave level 0.
    a_r10_boost_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode && !single_core_boost && lic_level == '0) |=> (lic_level == '0));
endmodule

// File: tb/vlic_ctrl_tb.sv
`timescale 1ns/1ps
module vlic_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_disable = 1'b0;
    logic       cfg_mode = 1'b0;
    logic [5:0] cfg_soft_thresh = 6'd1;
    logic [7:0] cfg_window = 8'd0;
    logic [9:0] cfg_holdoff = 10'd4;
    logic       single_core_boost = 1'b0;
    logic       retire_vld = 1'b0;
    logic [1:0] retire_width = 2'd0;
    logic       retire_heavy = 1'b0;
    logic [1:0] lic_level;
    logic [6:0] lic_ratio;

    int    n_checks = 0;
    int    n_errs   = 0;
    bit    done     = 1'b0;
    string tag      = "R1";

    int m_lvl, m_hold;
    int m_cnt [2];
    int m_idle[2];

    always #4 clk = ~clk;

    vlic_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_disable(cfg_disable), .cfg_mode(cfg_mode),
        .cfg_soft_thresh(cfg_soft_thresh), .cfg_window(cfg_window), .cfg_holdoff(cfg_holdoff),
        .single_core_boost(single_core_boost), .retire_vld(retire_vld),
        .retire_width(retire_width), .retire_heavy(retire_heavy),
        .lic_level(lic_level), .lic_ratio(lic_ratio)
    );

    function automatic int exp_ratio();
        if (m_lvl == 0) return 100;
        if (cfg_mode)   return 97;
        return (m_lvl == 1) ? 85 : 60;
    endfunction

    task automatic model_reset();
        m_lvl = 0; m_hold = 0;
        for (int k = 0; k < 2; k++) begin m_cnt[k] = 0; m_idle[k] = 0; end
    endtask

    // Reference update from the requirements, applied at each clock edge.
    task automatic model_update();
        int ct, raise, thr, hl;
        bit hit [2];
        ct = 0; raise = 0; hit[0] = 0; hit[1] = 0;
        if (retire_vld && !cfg_disable) begin
            if (!cfg_mode) begin
                if (retire_width == 2'd3) begin
                    if (retire_heavy) begin hit[1] = 1; ct = 2; end
                    else begin raise = 1; ct = 1; end
                end else if (retire_width == 2'd2 && retire_heavy) begin
                    hit[0] = 1; ct = 1;
                end
            end else if (retire_width == 2'd3 && single_core_boost) begin
                raise = 1; ct = 1;
            end
        end
        thr = (cfg_soft_thresh == 0) ? 1 : int'(cfg_soft_thresh);
        for (int k = 0; k < 2; k++) begin
            if (cfg_disable || m_lvl >= k + 1) begin
                m_cnt[k] = 0; m_idle[k] = 0;
            end else if (hit[k]) begin
                m_idle[k] = 0;
                if (m_cnt[k] + 1 >= thr) begin
                    if (k + 1 > raise) raise = k + 1;
                    m_cnt[k] = 0;
                end else m_cnt[k]++;
            end else if (cfg_window != 0 && m_idle[k] + 1 >= int'(cfg_window)) begin
                m_cnt[k] = 0; m_idle[k] = 0;
            end else if (m_idle[k] < 255) m_idle[k]++;
        end
        hl = (cfg_holdoff == 0) ? 1 : int'(cfg_holdoff);
        if (cfg_disable) begin m_lvl = 0; m_hold = 0; end
        else if (raise > m_lvl) begin m_lvl = raise; m_hold = 0; end
        else if (m_lvl == 0 || (ct != 0 && ct >= m_lvl)) m_hold = 0;
        else if (m_hold + 1 >= hl) begin m_lvl--; m_hold = 0; end
        else m_hold++;
    endtask

    task automatic check_out();
        n_checks++;
        if (int'(lic_level) != m_lvl || int'(lic_ratio) != exp_ratio()) begin
            n_errs++;
            $display("FAIL %s: level=%0d ratio=%0d expected level=%0d ratio=%0d",
                     tag, lic_level, lic_ratio, m_lvl, exp_ratio());
        end
    endtask

    // One cycle: drive at the falling edge, update the model at the rising edge, check after.
    task automatic step(input bit v, input logic [1:0] w, input bit h);
        @(negedge clk);
        retire_vld = v; retire_width = w; retire_heavy = h;
        @(posedge clk);
        model_update();
        #1;
        check_out();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 2'd0, 1'b0);
    endtask

    task automatic expect_level(input int lv, input string t);
        n_checks++;
        if (int'(lic_level) != lv) begin
            n_errs++;
            $display("FAIL %s: level=%0d expected level=%0d", t, lic_level, lv);
        end
    endtask

    task automatic settle();
        cfg_disable = 1'b1; idle(2); cfg_disable = 1'b0;
    endtask

    initial begin
        #1_600_000;
        if (!done) begin
            n_errs++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        tag = "R1"; #1; check_out();

        // R3 and R2: light 512 hard trigger, ratio 85.
        cfg_holdoff = 10'd5;
        tag = "R3"; step(1'b1, 2'd3, 1'b0); expect_level(1, "R3");
        tag = "R2"; check_out();
        // R8: drops after five quiet cycles.
        tag = "R8"; idle(4); expect_level(1, "R8"); idle(1); expect_level(0, "R8");

        // R4: three heavy 256 needed.
        cfg_soft_thresh = 6'd3;
        tag = "R4"; step(1'b1, 2'd2, 1'b1); step(1'b1, 2'd2, 1'b1); expect_level(0, "R4");
        step(1'b1, 2'd2, 1'b1); expect_level(1, "R4");
        settle();

        // R5: heavy 512 to level 2, ratio 60, then stepwise fall (R8).
        tag = "R5"; repeat (3) step(1'b1, 2'd3, 1'b1); expect_level(2, "R5");
        tag = "R2"; check_out();
        tag = "R8"; idle(5); expect_level(1, "R8"); idle(5); expect_level(0, "R8");

        // R6: window of 4 forgets two earlier hits.
        cfg_window = 8'd4;
        tag = "R6"; step(1'b1, 2'd2, 1'b1); step(1'b1, 2'd2, 1'b1); idle(4);
        step(1'b1, 2'd2, 1'b1); step(1'b1, 2'd2, 1'b1); expect_level(0, "R6");
        step(1'b1, 2'd2, 1'b1); expect_level(1, "R6");
        cfg_window = 8'd0; settle();

        // R7: narrow and light 256 do nothing.
        tag = "R7";
        for (int i = 0; i < 12; i++) step(1'b1, 2'(i % 3), (i % 3) != 2);
        expect_level(0, "R7");

        // R9: raise on the cycle the hold-off would expire.
        cfg_soft_thresh = 6'd2; cfg_holdoff = 10'd4;
        tag = "R9"; step(1'b1, 2'd3, 1'b0); step(1'b1, 2'd3, 1'b1); idle(3);
        step(1'b1, 2'd3, 1'b1); expect_level(2, "R9");
        settle();

        // R12: count does not build while level 1 is held.
        tag = "R12"; step(1'b1, 2'd3, 1'b0); step(1'b1, 2'd2, 1'b1); idle(4);
        expect_level(0, "R12"); step(1'b1, 2'd2, 1'b1); expect_level(0, "R12");
        settle();

        // R10: mode 1 gated by boost, never level 2.
        cfg_mode = 1'b1; tag = "R10";
        single_core_boost = 1'b0; repeat (4) step(1'b1, 2'd3, 1'b1); expect_level(0, "R10");
        single_core_boost = 1'b1; step(1'b1, 2'd3, 1'b0); expect_level(1, "R10");
        repeat (6) step(1'b1, 2'd3, 1'b1); expect_level(1, "R10");
        tag = "R2"; check_out();

        // R11: disable pins level 0.
        cfg_mode = 1'b0; tag = "R11"; step(1'b1, 2'd3, 1'b0);
        cfg_disable = 1'b1; step(1'b1, 2'd3, 1'b0); expect_level(0, "R11");
        for (int i = 0; i < 8; i++) step(1'b1, 2'(i % 4), i[0]);
        expect_level(0, "R11");
        cfg_disable = 1'b0;

        // Random segments under the reference model.
        for (int s = 0; s < 30; s++) begin
            cfg_mode          = $urandom_range(0, 3) == 0;
            cfg_soft_thresh   = 6'($urandom_range(0, 4));
            cfg_window        = 8'($urandom_range(0, 6));
            cfg_holdoff       = 10'($urandom_range(0, 8));
            cfg_disable       = $urandom_range(0, 9) == 0;
            tag = cfg_disable ? "R11" : (cfg_mode ? "R10" : "R8");
            for (int i = 0; i < 200; i++) begin
                single_core_boost = $urandom_range(0, 1) == 1;
                step($urandom_range(0, 2) != 0, 2'($urandom_range(0, 3)), $urandom_range(0, 1) == 1);
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end
endmodule